// File: doc/BRIEF.md
# Bus-attached seconds real-time clock

This block is a seconds timekeeper that sits on a simple 32-bit peripheral register bus with APB-style setup and access phases. It decodes a 4 KiB address window. A prescaler divides the system clock into a one-second tick. The tick advances a free-running seconds counter, which software reads and can also load with a new value.

Software arms an alarm by writing a match value. When the seconds counter steps onto that value, a sticky interrupt flag is set and drives the interrupt output. Software can also set or clear the flag directly through a single shared offset. A second counter reports the seconds elapsed since it was last rebased. Two constant identification words near the top of the window let a driver probe for the block.

Only full-word accesses take effect. Narrower transfers are dropped, and the error output reports them.

Top module: `rtc_seconds_apb`

## Requirements
- R1: The seconds value at offset 0x00 increases by exactly one for every PRESCALE system clocks, counted from reset release.
- R2: Writes to offset 0x00 leave the seconds value unchanged.
- R3: The match register at offset 0x04 reads back exactly the last 32-bit word written to it.
- R4: A word write to offset 0x08 sets the interrupt flag if the data is nonzero and clears it if the data is zero. The flag drives `irq` from the next cycle. A read of 0x08 returns the flag in bit 0 and zeros in bits 31:1.
- R5: When a tick moves the seconds value onto the match value, the flag is set. It then stays set until a zero is written to 0x08.
- R6: Offset 0x10 reads the seconds elapsed since the last write there. Any write data rebases it to zero.
- R7: A word write to offset 0x0C loads the seconds counter with the written data at that clock edge. A read of 0x0C returns zero.
- R8: Offset 0xFE0 reads 0x00041030 and offset 0xFD8 reads 0x000FFFFF. Writes to either offset change nothing.
- R9: A transfer whose `xfer_size` is not 2 has no effect. Size encodings are 0 = byte, 1 = halfword, 2 = word, 3 = reserved. During its access phase such a transfer drives `pslverr` high and `prdata` to zero.
- R10: A word read of any offset outside the map returns zero and raises `pslverr` for that access cycle.
- R11: After reset the seconds value, match value, elapsed count and flag are all zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset inside the window |
| pwdata | input | DATA_W | Write data |
| xfer_size | input | 2 | Transfer size code (2 = word) |
| prdata | output | DATA_W | Read data, valid during the access phase |
| pslverr | output | 1 | Error flag for a bad size or an unmapped read |
| irq | output | 1 | Level alarm interrupt |

## Verification
Read data and `pslverr` are combinational during the access phase, so the bench samples them in that same cycle, between its falling edge and the closing rising edge. Register writes, loads, rebases and flag changes take effect at the rising edge that ends the access phase, and they are observed from the next cycle onward. Tick-dependent values are read after a whole multiple of PRESCALE clock edges measured from the load or rebase edge, and every edge in between is counted, including the setup edge of the read. Such a window holds an exact number of ticks, so the expected seconds, elapsed count and alarm state are exact rather than ranges. The one exception is the ignored write to offset 0x00, which is checked against a one-tick tolerance.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } xfer_size_e;

   localparam logic [11:0] OFS_NOW     = 12'h000;
   localparam logic [11:0] OFS_MATCH   = 12'h004;
   localparam logic [11:0] OFS_FLAG    = 12'h008;
   localparam logic [11:0] OFS_LOAD    = 12'h00C;
   localparam logic [11:0] OFS_ELAPSED = 12'h010;
   localparam logic [11:0] OFS_MASKID  = 12'hFD8;
   localparam logic [11:0] OFS_IDENT   = 12'hFE0;

   localparam logic [31:0] IDENT_WORD  = 32'h0004_1030;
   localparam logic [31:0] MASK_WORD   = 32'h000F_FFFF;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int PRESCALE = 50_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (PRESCALE < 1) begin : g_bad
         $error("rtc_prescaler: PRESCALE must be at least 1");
      end else if (PRESCALE == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(PRESCALE);
         localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad
         $error("rtc_sec_counter: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= load_val;
      else if (tick) q <= q + 1'b1;
   end
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_wr,
   input  logic sw_set,
   input  logic hit,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag <= 1'b0;
      else if (sw_wr) flag <= sw_set;
      else if (hit)   flag <= 1'b1;
   end
endmodule

// File: rtl/rtc_seconds_apb.sv
module rtc_seconds_apb
   import rtc_pkg::*;
#(
   parameter int PRESCALE = 50_000_000,
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   input  logic [1:0]        xfer_size,
   output logic [DATA_W-1:0] prdata,
   output logic              pslverr,
   output logic              irq
);
   localparam int OW = 12;

   generate
      if (ADDR_W != OW) begin : g_bad_addr
         $error("rtc_seconds_apb: ADDR_W must be 12 for a 4 KiB window");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("rtc_seconds_apb: DATA_W must be 32");
      end
   endgenerate

   logic              acc, size_ok, wr_ok, rd_ok, known;
   logic              tick, ld_sec, ld_el, flag_wr, hit;
   logic [DATA_W-1:0] sec_q, el_q, match_q, rd_mux;

   assign acc     = psel & penable;
   assign size_ok = (xfer_size == SZ_WORD);
   assign wr_ok   = acc & pwrite & size_ok;
   assign rd_ok   = acc & ~pwrite & size_ok;

   assign ld_sec  = wr_ok & (paddr == OFS_LOAD);
   assign ld_el   = wr_ok & (paddr == OFS_ELAPSED);
   assign flag_wr = wr_ok & (paddr == OFS_FLAG);

   rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   rtc_sec_counter #(.W(DATA_W)) u_sec (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .load(ld_sec), .load_val(pwdata), .q(sec_q)
   );

   rtc_sec_counter #(.W(DATA_W)) u_elapsed (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .load(ld_el), .load_val('0), .q(el_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            match_q <= '0;
      else if (wr_ok && paddr == OFS_MATCH)  match_q <= pwdata;
   end

   assign hit = tick & ~ld_sec & ((sec_q + 1'b1) == match_q);

   rtc_alarm_flag u_flag (
      .clk(clk), .rst_n(rst_n), .sw_wr(flag_wr),
      .sw_set(|pwdata), .hit(hit), .flag(irq)
   );

   always_comb begin
      known  = 1'b1;
      rd_mux = '0;
      case (paddr)
         OFS_NOW:     rd_mux = sec_q;
         OFS_MATCH:   rd_mux = match_q;
         OFS_FLAG:    rd_mux = {{(DATA_W-1){1'b0}}, irq};
         OFS_LOAD:    rd_mux = '0;
         OFS_ELAPSED: rd_mux = el_q;
         OFS_MASKID:  rd_mux = MASK_WORD;
         OFS_IDENT:   rd_mux = IDENT_WORD;
         default:     known  = 1'b0;
      endcase
   end

   assign prdata  = rd_ok ? rd_mux : '0;
   assign pslverr = acc & (~size_ok | (~pwrite & ~known));
endmodule

// File: rtl/rtc_seconds_chk.sv
module rtc_seconds_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        psel,
   input logic        penable,
   input logic        pwrite,
   input logic [11:0] paddr,
   input logic [31:0] pwdata,
   input logic [1:0]  xfer_size,
   input logic [31:0] prdata,
   input logic        pslverr,
   input logic        irq,
   input logic [31:0] sec_q
);
   logic acc_w, wr_word;
   assign acc_w   = psel & penable & pwrite;
   assign wr_word = acc_w & (xfer_size == 2'd2);

   assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_word && paddr == 12'h008 && pwdata != 32'd0) |=> irq);

   assert_flag_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_word && paddr == 12'h008 && pwdata == 32'd0) |=> !irq);

   assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(wr_word && paddr == 12'h008)) |=> irq);

   assert_bad_size_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && xfer_size != 2'd2) |-> (pslverr && prdata == 32'd0));

   assert_err_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && !pwrite && pslverr) |-> (prdata == 32'd0));

   assert_sec_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_word && paddr == 12'h00C) |=>
         (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 32'd1));
endmodule

bind rtc_seconds_apb rtc_seconds_chk u_chk (
   .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
   .paddr(paddr), .pwdata(pwdata), .xfer_size(xfer_size), .prdata(prdata),
   .pslverr(pslverr), .irq(irq), .sec_q(sec_q)
);

// File: tb/tb_rtc_seconds_apb.sv
module tb_rtc_seconds_apb;
   localparam int P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [1:0]  xfer_size = 2'd2;
   logic [31:0] prdata;
   logic        pslverr, irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rtc_seconds_apb #(.PRESCALE(P)) dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .xfer_size(xfer_size),
      .prdata(prdata), .pslverr(pslverr), .irq(irq)
   );

   typedef struct packed {
      logic        wr;
      logic [1:0]  sz;
      logic [11:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic        err;
   } vec_t;

   localparam vec_t VECS [11] = '{
      '{1'b1, 2'd2, 12'h004, 32'h0403_0201, 32'h0,          1'b0}, // R3
      '{1'b0, 2'd2, 12'h004, 32'h0,         32'h0403_0201,  1'b0}, // R3
      '{1'b0, 2'd2, 12'hFE0, 32'h0,         32'h0004_1030,  1'b0}, // R8
      '{1'b0, 2'd2, 12'hFD8, 32'h0,         32'h000F_FFFF,  1'b0}, // R8
      '{1'b0, 2'd2, 12'h00C, 32'h0,         32'h0,          1'b0}, // R7
      '{1'b0, 2'd2, 12'h100, 32'h0,         32'h0,          1'b1}, // R10
      '{1'b1, 2'd0, 12'h004, 32'hDEAD_BEEF, 32'h0,          1'b1}, // R9
      '{1'b0, 2'd2, 12'h004, 32'h0,         32'h0403_0201,  1'b0}, // R9
      '{1'b0, 2'd1, 12'h004, 32'h0,         32'h0,          1'b1}, // R9
      '{1'b1, 2'd2, 12'hFE0, 32'h1234_5678, 32'h0,          1'b0}, // R8
      '{1'b0, 2'd2, 12'hFE0, 32'h0,         32'h0004_1030,  1'b0}  // R8
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // starts at a falling edge; the sample is taken inside the access phase
   task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic [1:0] sz, output logic [31:0] rd, output logic err);
      psel = 1'b1; pwrite = wr; paddr = a; pwdata = d; xfer_size = sz;
      @(posedge clk);
      @(negedge clk);
      penable = 1'b1;
      #1;
      rd = prdata; err = pslverr;
      @(posedge clk);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic wr32(input logic [11:0] a, input logic [31:0] d);
      logic [31:0] r; logic e;
      xfer(1'b1, a, d, 2'd2, r, e);
   endtask

   task automatic rd32(input logic [11:0] a, output logic [31:0] r);
      logic e;
      xfer(1'b0, a, 32'h0, 2'd2, r, e);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic e;
      idle(3);
      rst_n = 1'b1;

      // R11: reset state
      chk("R11 irq", {31'd0, irq}, 32'd0);
      rd32(12'h000, r); chk("R11 seconds", r, 32'd0);
      rd32(12'h008, r); chk("R11 flag", r, 32'd0);
      rd32(12'h010, r); chk("R11 elapsed", r, 32'd0);
      rd32(12'h004, r); chk("R11 match", r, 32'd0);

      // table walk
      foreach (VECS[i]) begin
         xfer(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].sz, r, e);
         if (!VECS[i].wr) chk($sformatf("vec%0d data", i), r, VECS[i].exp);
         chk($sformatf("vec%0d err", i), {31'd0, e}, {31'd0, VECS[i].err});
      end

      // R7 / R1: load, then read after exactly 5*P edges
      wr32(12'h00C, 32'd100);
      idle(5*P - 1);
      rd32(12'h000, r); chk("R1 R7 seconds after 5 ticks", r, 32'd105);

      // R2: write to 0x00 ignored
      wr32(12'h00C, 32'd1000);
      wr32(12'h000, 32'hFFFF_0000);
      rd32(12'h000, r);
      n_chk++;
      if (r != 32'd1000 && r != 32'd1001) begin
         n_fail++;
         $display("FAIL R2 actual=%h expected=1000..1001", r);
      end

      // R6: rebase elapsed, read after exactly 3*P edges
      idle(2*P + 3);
      wr32(12'h010, 32'hABCD_0001);
      idle(3*P - 1);
      rd32(12'h010, r); chk("R6 elapsed", r, 32'd3);

      // R4: software set/clear
      wr32(12'h008, 32'h0000_0005);
      chk("R4 irq set", {31'd0, irq}, 32'd1);
      rd32(12'h008, r); chk("R4 flag read", r, 32'd1);
      wr32(12'h008, 32'h0);
      chk("R4 irq clear", {31'd0, irq}, 32'd0);
      rd32(12'h008, r); chk("R4 flag read clear", r, 32'd0);

      // R5: alarm at match
      wr32(12'h004, 32'd202);
      wr32(12'h00C, 32'd200);
      idle(P - 1);
      rd32(12'h008, r); chk("R5 no alarm at 201", r, 32'd0);
      idle(P - 2);
      rd32(12'h008, r); chk("R5 alarm at 202", r, 32'd1);
      chk("R5 irq", {31'd0, irq}, 32'd1);
      idle(3*P);
      rd32(12'h008, r); chk("R5 sticky", r, 32'd1);
      wr32(12'h008, 32'h0);
      rd32(12'h008, r); chk("R5 cleared", r, 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule